// File: doc/BRIEF.md
# Real-time clock register bank with staged commit

This block is the 16-bit register file of a real-time clock. A simple synchronous bus (byte address, write enable, write data, combinational read data) reaches a control word, an interrupt status word, an interrupt enable word, seven time words and seven alarm words. Bus writes to time and alarm words do not touch the running clock. They land in a staging copy. The live time and the live alarm are only replaced when software writes the value 1 to a trigger word. This lets software program a full date or alarm without the clock carrying between field writes.

After a trigger, a busy flag reads as set for a parameterised number of cycles. On the edge where busy drops, all fourteen staged fields become live in the same cycle. The live calendar advances on a one-second tick input and follows month lengths, leap years, and day-of-week wrap. Reads of the time words return the live counter. Software that reads several words may therefore see a carry between reads, and should re-read the seconds word to detect this. Interrupt status bits are set by event inputs and cleared by writing ones. An interrupt output is raised while any enabled status bit is set.

Top module: `rtcb_bank`

## Requirements
- R1: After reset, the time words read seconds 0, minutes 0, hour 0, day of month 1, day of week 0, month 1 and year 0. The control, status and enable words read 0.
- R2: Each register sits at a fixed byte address:
  - 0x00 is the control word, and bit 6 of it is busy.
  - 0x02 is interrupt status and 0x04 is interrupt enable.
  - 0x0A..0x16 are the time words, every 2 bytes, in the order seconds, minutes, hour, day of month, day of week, month, year. The year is an offset from 1968 and the month is 1-based.
  - 0x18..0x24 are the alarm words in the same order.
  - 0x3C is the trigger.
  - Any other address reads 0.
- R3: A write to a time or alarm word changes nothing visible until a commit. Reads keep returning the live value.
- R4: Writing exactly 1 to the trigger while not busy sets busy for BUSY_CYC cycles. On the edge that clears busy, every staged time and alarm field becomes live. A trigger write of any other value is ignored.
- R5: While busy, writes to time words, alarm words and the trigger are ignored.
- R6: A tick that arrives on the commit edge is dropped. The committed time is visible unchanged.
- R7: Each tick advances seconds 0..59, then carries into minutes 0..59, then into hours 0..23. Day of week 0..6 advances at the day carry and wraps to 0.
- R8: The day of month wraps to 1 after the last day of the month: 30 for months 4, 6, 9 and 11, 31 for the others, and for February 29 when year mod 4 is 0, otherwise 28. The month wraps from 12 to 1 and increments the year, and the year wraps from 127 to 0.
- R9: Fields keep only their low bits and read back zero-extended. The widths are seconds 6, minutes 6, hour 5, day of month 5, day of week 3, month 4 and year 7.
- R10: A high event input sets its status bit. Writing a 1 to a status bit clears it, and a set in the same cycle wins. The enable word is read/write. The irq output is high while any bit of status AND enable is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_1s | input | 1 | One-second advance strobe |
| bus_we | input | 1 | Bus write enable |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr |
| irq_evt | input | IRQ_W | Interrupt event inputs |
| irq | output | 1 | Enabled pending interrupt |

## Verification
The commit path is tried with several write patterns:
- a trigger of the wrong value, which must leave busy clear;
- a correct trigger followed by a seconds write and a second trigger inside the busy window, which must both be lost;
- a tick placed exactly on the commit edge, which separates a design that lets the tick win from one that drops it.

The calendar is tried from staged dates that sit one tick before a rollover: 28 February in a non-leap and in a leap year, 31 December at year 127, and a plain minute carry. Each of these tells apart a different wrong month-length or carry rule. Interrupt tests set, mask, clear, and collide set with clear.

// File: rtl/rtcb_pkg.sv
package rtcb_pkg;

  localparam int WORD_W    = 16;
  localparam int NFLD      = 7;
  localparam int NBANK     = 2;
  localparam int CTRL_OFS  = 'h00;
  localparam int STA_OFS   = 'h02;
  localparam int EN_OFS    = 'h04;
  localparam int TIME_OFS  = 'h0A;
  localparam int ALARM_OFS = 'h18;
  localparam int TRIG_OFS  = 'h3C;
  localparam int BUSY_BIT  = 6;

  typedef struct packed {
    logic [6:0] year;
    logic [3:0] mon;
    logic [2:0] dow;
    logic [4:0] dom;
    logic [4:0] hour;
    logic [5:0] min;
    logic [5:0] sec;
  } cal_t;

  localparam cal_t CAL_RST = '{year: 7'd0, mon: 4'd1, dow: 3'd0, dom: 5'd1,
                               hour: 5'd0, min: 6'd0, sec: 6'd0};

  function automatic logic [4:0] month_days(logic [3:0] mon, logic [6:0] year);
    case (mon)
      4'd4, 4'd6, 4'd9, 4'd11: return 5'd30;
      4'd2:                    return (year[1:0] == 2'b00) ? 5'd29 : 5'd28;
      default:                 return 5'd31;
    endcase
  endfunction

  function automatic cal_t cal_put(cal_t c, int f, logic [WORD_W-1:0] d);
    cal_t n = c;
    case (f)
      0: n.sec  = d[5:0];
      1: n.min  = d[5:0];
      2: n.hour = d[4:0];
      3: n.dom  = d[4:0];
      4: n.dow  = d[2:0];
      5: n.mon  = d[3:0];
      default: n.year = d[6:0];
    endcase
    return n;
  endfunction

  function automatic logic [WORD_W-1:0] cal_get(cal_t c, int f);
    case (f)
      0: return {10'd0, c.sec};
      1: return {10'd0, c.min};
      2: return {11'd0, c.hour};
      3: return {11'd0, c.dom};
      4: return {13'd0, c.dow};
      5: return {12'd0, c.mon};
      default: return {9'd0, c.year};
    endcase
  endfunction

  function automatic cal_t cal_step(cal_t c);
    cal_t n = c;
    if (c.sec != 6'd59) n.sec = c.sec + 6'd1;
    else begin
      n.sec = 6'd0;
      if (c.min != 6'd59) n.min = c.min + 6'd1;
      else begin
        n.min = 6'd0;
        if (c.hour != 5'd23) n.hour = c.hour + 5'd1;
        else begin
          n.hour = 5'd0;
          n.dow  = (c.dow >= 3'd6) ? 3'd0 : c.dow + 3'd1;
          if (c.dom < month_days(c.mon, c.year)) n.dom = c.dom + 5'd1;
          else begin
            n.dom = 5'd1;
            if (c.mon >= 4'd12) begin
              n.mon  = 4'd1;
              n.year = c.year + 7'd1;
            end else n.mon = c.mon + 4'd1;
          end
        end
      end
    end
    return n;
  endfunction

endpackage

// File: rtl/rtcb_commit.sv
module rtcb_commit
  import rtcb_pkg::*;
#(
  parameter int ADDR_W   = 6,
  parameter int DATA_W   = WORD_W,
  parameter int BUSY_CYC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              busy,
  output logic              trig_ok,
  output logic              commit_fire
);
  localparam int CNT_W = $clog2(BUSY_CYC + 1);

  logic [CNT_W-1:0] cnt_q;

  assign busy        = (cnt_q != '0);
  assign commit_fire = (cnt_q == CNT_W'(1));
  assign trig_ok     = wr_en && !busy && (wr_addr == ADDR_W'(TRIG_OFS)) &&
                       (wr_data == DATA_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt_q <= '0;
    else if (trig_ok) cnt_q <= CNT_W'(BUSY_CYC);
    else if (busy)    cnt_q <= cnt_q - CNT_W'(1);
  end

  p_trig_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    trig_ok |=> busy);
  p_fire_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    commit_fire |=> !busy);
  p_no_retrig_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !commit_fire) |=> busy);

endmodule

// File: rtl/rtcb_stage.sv
module rtcb_stage
  import rtcb_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              busy,
  output cal_t              stg_time,
  output cal_t              stg_alarm
);
  cal_t stg_q [NBANK];

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    localparam int BASE = (b == 0) ? TIME_OFS : ALARM_OFS;
    int   off;
    logic hit;

    always_comb begin
      off = int'(wr_addr) - BASE;
      hit = wr_en && !busy && !wr_addr[0] && (off >= 0) && (off < 2 * NFLD);
    end

    always_ff @(posedge clk) begin
      if (!rst_n)   stg_q[b] <= CAL_RST;
      else if (hit) stg_q[b] <= cal_put(stg_q[b], off / 2, wr_data);
    end

    p_stage_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(stg_q[b]));
  end

  assign stg_time  = stg_q[0];
  assign stg_alarm = stg_q[1];

endmodule

// File: rtl/rtcb_calendar.sv
module rtcb_calendar
  import rtcb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic load,
  input  cal_t load_val,
  output cal_t now
);
  always_ff @(posedge clk) begin
    if (!rst_n)    now <= CAL_RST;
    else if (load) now <= load_val;
    else if (tick) now <= cal_step(now);
  end

  p_load_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (now == $past(load_val)));
  p_sec_adv_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load && now.sec < 6'd59) |=> (now.sec == $past(now.sec) + 6'd1));
  p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load) |=> $stable(now));

endmodule

// File: rtl/rtcb_bank.sv
module rtcb_bank
  import rtcb_pkg::*;
#(
  parameter int ADDR_W   = 6,
  parameter int DATA_W   = WORD_W,
  parameter int BUSY_CYC = 4,
  parameter int IRQ_W    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_1s,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [IRQ_W-1:0]  irq_evt,
  output logic              irq
);
  logic busy, trig_ok, commit_fire;
  cal_t stg_time, stg_alarm, time_now, alarm_live;
  logic [IRQ_W-1:0] sta_q, en_q, sta_clr;
  int   rd_toff, rd_aoff;

  rtcb_commit #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BUSY_CYC(BUSY_CYC)) u_commit (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_we), .wr_addr(bus_addr),
    .wr_data(bus_wdata), .busy(busy), .trig_ok(trig_ok), .commit_fire(commit_fire));

  rtcb_stage #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_stage (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_we), .wr_addr(bus_addr),
    .wr_data(bus_wdata), .busy(busy), .stg_time(stg_time), .stg_alarm(stg_alarm));

  rtcb_calendar u_cal (
    .clk(clk), .rst_n(rst_n), .tick(tick_1s), .load(commit_fire),
    .load_val(stg_time), .now(time_now));

  always_ff @(posedge clk) begin
    if (!rst_n)           alarm_live <= CAL_RST;
    else if (commit_fire) alarm_live <= stg_alarm;
  end

  assign sta_clr = (bus_we && bus_addr == ADDR_W'(STA_OFS)) ? bus_wdata[IRQ_W-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sta_q <= '0;
      en_q  <= '0;
    end else begin
      sta_q <= (sta_q & ~sta_clr) | irq_evt;
      if (bus_we && bus_addr == ADDR_W'(EN_OFS)) en_q <= bus_wdata[IRQ_W-1:0];
    end
  end

  assign irq = |(sta_q & en_q);

  always_comb begin
    rd_toff   = int'(bus_addr) - TIME_OFS;
    rd_aoff   = int'(bus_addr) - ALARM_OFS;
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(CTRL_OFS))     bus_rdata[BUSY_BIT] = busy;
    else if (bus_addr == ADDR_W'(STA_OFS)) bus_rdata = DATA_W'(sta_q);
    else if (bus_addr == ADDR_W'(EN_OFS))  bus_rdata = DATA_W'(en_q);
    else if (!bus_addr[0] && rd_toff >= 0 && rd_toff < 2 * NFLD)
      bus_rdata = cal_get(time_now, rd_toff / 2);
    else if (!bus_addr[0] && rd_aoff >= 0 && rd_aoff < 2 * NFLD)
      bus_rdata = cal_get(alarm_live, rd_aoff / 2);
  end

  p_alarm_commit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    commit_fire |=> (alarm_live == $past(stg_alarm)));
  p_alarm_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_fire |=> $stable(alarm_live));
  p_sta_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_evt[0] |=> sta_q[0]);
  p_sta_w1c_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == ADDR_W'(STA_OFS) && bus_wdata[0] && !irq_evt[0]) |=> !sta_q[0]);

endmodule

// File: tb/rtcb_bank_tb_top.sv
`timescale 1ns/1ps
module rtcb_bank_tb_top;
  localparam int AW = 6, DW = 16, BC = 4, IW = 4;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, we = 1'b0, irq;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0, rdata;
  logic [IW-1:0] evt = '0;

  always #2.5 clk = ~clk;

  rtcb_bank #(.ADDR_W(AW), .DATA_W(DW), .BUSY_CYC(BC), .IRQ_W(IW)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick_1s(tick), .bus_we(we), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata), .irq_evt(evt), .irq(irq));

  typedef struct { bit is_irq; logic [DW-1:0] exp; string tag; } item_t;
  item_t sb[$];
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  task automatic drive(bit w, int a, int d, bit t = 1'b0, int e = 0);
    @(posedge clk); #1;
    we = w; addr = AW'(a); wdata = DW'(d); tick = t; evt = IW'(e);
  endtask
  task automatic wr(int a, int d); drive(1'b1, a, d); endtask
  task automatic idle(int n); for (int i = 0; i < n; i++) drive(1'b0, 0, 0); endtask
  task automatic tk(); drive(1'b0, 0, 0, 1'b1); endtask
  task automatic rd(int a, int ex, string tg, bit t = 1'b0);
    item_t it;
    drive(1'b0, a, 0, t);
    it.is_irq = 1'b0; it.exp = DW'(ex); it.tag = tg;
    sb.push_back(it);
  endtask
  task automatic chk_irq(bit ex, string tg);
    item_t it;
    drive(1'b0, 0, 0);
    it.is_irq = 1'b1; it.exp = DW'(ex); it.tag = tg;
    sb.push_back(it);
  endtask
  task automatic commit(); wr('h3C, 1); idle(5); endtask

  // monitor: compares results mid-cycle against the scoreboard queue
  always @(negedge clk) begin
    item_t it;
    logic [DW-1:0] act;
    if (sb.size() > 0) begin
      it  = sb.pop_front();
      act = it.is_irq ? DW'(irq) : rdata;
      n_chk++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    rd('h00, 0, "R1 ctrl"); rd('h0A, 0, "R1 sec"); rd('h10, 1, "R1 dom");
    rd('h14, 1, "R1 month"); rd('h16, 0, "R1 year"); rd('h02, 0, "R1 status");
    rd('h04, 0, "R1 enable");
    // R3 staging, non-leap Feb 28 1969 23:59:58
    wr('h0A, 58); wr('h0C, 59); wr('h0E, 23); wr('h10, 28); wr('h12, 6);
    wr('h14, 2); wr('h16, 1); wr('h1C, 'hFFFF);
    rd('h0A, 0, "R3 live sec before commit"); rd('h1C, 0, "R3 alarm hour before commit");
    wr('h3C, 2); rd('h00, 0, "R4 trigger value 2 ignored");
    wr('h3C, 1); rd('h00, 'h40, "R4 busy set");
    wr('h0A, 5); wr('h3C, 1);
    rd('h00, 'h40, "R5 busy in last cycle", 1'b1);
    rd('h00, 0, "R4 busy cleared after BUSY_CYC");
    rd('h0A, 58, "R6 tick dropped and R5 write ignored");
    rd('h0C, 59, "R4 min"); rd('h0E, 23, "R4 hour"); rd('h10, 28, "R4 dom");
    rd('h12, 6, "R4 dow"); rd('h14, 2, "R2 month"); rd('h16, 1, "R2 year");
    rd('h1C, 'h1F, "R9 alarm hour masked");
    // R7 / R8 rollovers
    tk(); rd('h0A, 59, "R7 sec advance");
    tk(); rd('h0A, 0, "R7 sec wrap"); rd('h0C, 0, "R7 min wrap"); rd('h0E, 0, "R7 hour wrap");
    rd('h10, 1, "R8 Feb non-leap end"); rd('h14, 3, "R8 March"); rd('h12, 0, "R7 dow wrap");
    wr('h0A, 59); wr('h0C, 59); wr('h0E, 23); wr('h10, 28); wr('h14, 2); wr('h16, 0);
    commit(); tk();
    rd('h10, 29, "R8 leap Feb 29"); rd('h14, 2, "R8 leap month");
    wr('h10, 31); wr('h14, 12); wr('h16, 'hFFFF); commit();
    rd('h16, 127, "R9 year masked");
    tk(); rd('h10, 1, "R8 Dec wrap dom"); rd('h14, 1, "R8 Jan"); rd('h16, 0, "R8 year wrap");
    wr('h0C, 5); commit(); tk();
    rd('h0C, 6, "R7 min carry"); rd('h0E, 23, "R7 hour held"); rd('h0A, 0, "R7 sec zero");
    // R10 interrupts
    drive(1'b0, 0, 0, 1'b0, 1);
    rd('h02, 1, "R10 status set"); chk_irq(1'b0, "R10 irq masked");
    wr('h04, 1); rd('h04, 1, "R10 enable"); chk_irq(1'b1, "R10 irq raised");
    wr('h02, 1); rd('h02, 0, "R10 w1c"); chk_irq(1'b0, "R10 irq cleared");
    drive(1'b1, 'h02, 1, 1'b0, 1); rd('h02, 1, "R10 set wins over clear");
    rd('h30, 0, "R2 unmapped");
    idle(3);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule